// File: doc/BRIEF.md
# GHASH Galois-Field Multiply Unit

This block multiplies 128-bit values in GF(2^128) for GHASH-style message authentication. It offers two operations, chosen by a one-bit opcode. The plain multiply returns the field product of an accumulator Y and a hash key H. The hash step first folds a data block X into Y by XOR and then multiplies the sum by H. Every operand and the result use a per-byte mirrored bit order: bytes stay in place and the eight bits inside each byte are reversed. After mirroring, bit j of a value is the coefficient of x^j. Products are reduced modulo x^128 + x^7 + x^2 + x + 1. The core works serially, one key bit per clock. It shifts the key left and folds the low reduction constant 0x87 back in whenever bit 127 falls out.

A wrapper runs the core over a vector of 128-bit groups. Each group holds four 32-bit elements. A pulse on `go` captures the whole vector, a start element index, an active length, a total element count and a tail-fill flag. The wrapper then processes every group from start/4 up to, but not including, length/4. Groups outside that range keep their accumulator values. When the flag is set, the elements from the length up to the total count are filled with ones. A one-cycle `done` pulse returns the finished vector.

Top module: `ghash_gfmul_unit`

## Requirements
- R1: After reset `busy` and `done` are 0 and `res_vec` is all zeros.
- R2: With `op`=0, a group whose Y is 128'h80 (the field unit in mirrored byte order) returns its H group unchanged.
- R3: With `op`=0, each processed group holds the product of Y and H. The product is taken after mirroring the bits inside every byte, with bit j as the coefficient of x^j, reduced modulo x^128+x^7+x^2+x+1, and mirrored per byte again. A zero operand gives zero, and swapping Y and H gives the same result.
- R4: With `op`=1, each processed group holds the R3 product of (Y XOR X) and H. With X equal to zero it equals the `op`=0 result.
- R5: Group g occupies bits [128g+127:128g] of each vector, and element e occupies bits [32e+31:32e]. Groups g with start_elem/4 <= g < min(len_elem/4, NGROUPS) are computed. All other groups return their Y value, except where R6 applies.
- R6: When `tail_ones` is 1, every element e with len_elem <= e < total_elem reads all ones. When `tail_ones` is 0 those elements keep Y. Elements at or above total_elem always keep Y.
- R7: `done` is high for exactly one cycle, 130*G+2 clock edges after the edge that accepts `go`, where G is the number of computed groups. `busy` is high from the cycle after acceptance until `done` rises.
- R8: `go` is accepted only while `busy` is 0. The inputs are captured on the accepting edge, so changes to the inputs and further `go` pulses during a run do not affect the result or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a run over the captured vector |
| op | input | 1 | 0 = multiply, 1 = hash step |
| start_elem | input | CNT_W | First element index; the first group is start_elem/4 |
| len_elem | input | CNT_W | Active length in elements |
| total_elem | input | CNT_W | Total element count for tail fill |
| tail_ones | input | 1 | Fill tail elements with ones |
| vec_y | input | NGROUPS*128 | Accumulator groups Y |
| vec_x | input | NGROUPS*128 | Data groups X |
| vec_h | input | NGROUPS*128 | Hash key groups H |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse; res_vec valid |
| res_vec | output | NGROUPS*128 | Result vector |

## Verification
The hardest case to reach from the ports is a second `go` that arrives, together with new operands, while the serial core is partway through its 128 iterations. A correct result then depends on the capture made at acceptance and not on the live inputs. The bench starts a run, waits a few cycles, changes every operand vector, and pulses `go` again. It then checks that the result and the latency still match the first set of operands. Ranges that are not aligned to groups are exercised by starting and ending mid-group. Other cases covered are an empty range, in which the start group lies beyond the end, and a tail that stops before the vector end.

// File: rtl/ghash_pkg.sv
// Shared types and helpers for the GHASH multiply unit.
// Assumes 128-bit blocks made of 32-bit elements.
package ghash_pkg;
    localparam int BLK_W         = 128;
    localparam int ELEM_W        = 32;
    localparam int ELEMS_PER_BLK = BLK_W / ELEM_W;

    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic {
        OP_MUL  = 1'b0,
        OP_HASH = 1'b1
    } ghash_op_e;

    localparam blk_t RED_CONST = blk_t'(8'h87);

    // Reverses the bit order within every byte; byte positions are unchanged.
    function automatic blk_t byte_mirror(input blk_t v);
        blk_t r;
        for (int b = 0; b < BLK_W / 8; b++) begin
            for (int k = 0; k < 8; k++) begin
                r[8*b + k] = v[8*b + 7 - k];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/ghash_mul_core.sv
// Serial GF(2^128) multiplier: one key bit per clock, BLK_W iterations.
// It captures its operands on an accepted start. done pulses one cycle
// after the last iteration, with z_out valid. start is ignored while busy.
module ghash_mul_core
    import ghash_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  ghash_op_e op,
    input  blk_t      y_in,
    input  blk_t      x_in,
    input  blk_t      h_in,
    output logic      busy,
    output logic      done,
    output blk_t      z_out
);
    localparam int            CNT_W = $clog2(BLK_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_W - 1);

    blk_t             sel_q;
    blk_t             key_q;
    blk_t             acc_q;
    logic [CNT_W-1:0] iter_q;
    blk_t             acc_nxt;
    blk_t             key_nxt;

    // One iteration: conditional accumulate, then shift the key and reduce.
    always_comb begin
        acc_nxt = acc_q ^ (sel_q[0] ? key_q : '0);
        key_nxt = {key_q[BLK_W-2:0], 1'b0} ^ (key_q[BLK_W-1] ? RED_CONST : '0);
    end

    // Operand capture and iteration control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            key_q  <= '0;
            acc_q  <= '0;
            iter_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            z_out  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                sel_q  <= byte_mirror((op == OP_HASH) ? (y_in ^ x_in) : y_in);
                key_q  <= byte_mirror(h_in);
                acc_q  <= '0;
                iter_q <= '0;
                busy   <= 1'b1;
            end else if (busy) begin
                sel_q  <= sel_q >> 1;
                key_q  <= key_nxt;
                acc_q  <= acc_nxt;
                iter_q <= iter_q + 1'b1;
                if (iter_q == LAST) begin
                    z_out <= byte_mirror(acc_nxt);
                    done  <= 1'b1;
                    busy  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/ghash_group_seq.sv
// Walks the group index from start/ELEMS_PER_BLK to min(len/ELEMS_PER_BLK,
// NGROUPS). It launches the core once per group and flags the write-back
// and finish cycles. It assumes the core's done arrives after each launch.
module ghash_group_seq
    import ghash_pkg::*;
#(
    parameter int NGROUPS = 4,
    parameter int CNT_W   = 5,
    parameter int GSEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CNT_W-1:0]  start_elem,
    input  logic [CNT_W-1:0]  len_elem,
    input  logic              core_done,
    output logic              busy,
    output logic              accept,
    output logic              core_start,
    output logic              wr_en,
    output logic              fin,
    output logic [GSEL_W-1:0] grp_sel
);
    localparam int               SHIFT = $clog2(ELEMS_PER_BLK);
    localparam logic [CNT_W-1:0] GMAX  = CNT_W'(NGROUPS);

    typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_FIN} seq_state_e;

    seq_state_e       state_q;
    logic [CNT_W-1:0] grp_q;
    logic [CNT_W-1:0] end_q;
    logic [CNT_W-1:0] end_raw;

    // Last group bound, clamped to the vector size.
    always_comb begin
        end_raw = len_elem >> SHIFT;
        if (end_raw > GMAX) end_raw = GMAX;
    end

    // Handshake and strobe decode.
    always_comb begin
        busy       = (state_q != S_IDLE);
        accept     = (state_q == S_IDLE) && go;
        core_start = (state_q == S_LAUNCH) && (grp_q < end_q);
        wr_en      = (state_q == S_WAIT) && core_done;
        fin        = (state_q == S_FIN);
        grp_sel    = grp_q[GSEL_W-1:0];
    end

    // State and group index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            grp_q   <= '0;
            end_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (go) begin
                    grp_q   <= start_elem >> SHIFT;
                    end_q   <= end_raw;
                    state_q <= S_LAUNCH;
                end
                S_LAUNCH: state_q <= (grp_q < end_q) ? S_WAIT : S_FIN;
                S_WAIT: if (core_done) begin
                    grp_q   <= grp_q + 1'b1;
                    state_q <= S_LAUNCH;
                end
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ghash_tail_fill.sv
// Combinational tail fill: when enabled, it forces every element with
// index in [len, total) to all ones. Other elements pass through.
module ghash_tail_fill
    import ghash_pkg::*;
#(
    parameter int NELEM = 16,
    parameter int CNT_W = 5
) (
    input  logic [NELEM*ELEM_W-1:0] data_in,
    input  logic [CNT_W-1:0]        len,
    input  logic [CNT_W-1:0]        total,
    input  logic                    enable,
    output logic [NELEM*ELEM_W-1:0] data_out
);
    for (genvar e = 0; e < NELEM; e++) begin : g_elem
        localparam logic [CNT_W-1:0] IDX = CNT_W'(e);
        logic in_tail;
        // Element-level tail decision.
        assign in_tail = enable && (IDX >= len) && (IDX < total);
        assign data_out[e*ELEM_W +: ELEM_W] =
            in_tail ? {ELEM_W{1'b1}} : data_in[e*ELEM_W +: ELEM_W];
    end
endmodule

// File: rtl/ghash_gfmul_unit.sv
// Top of the GHASH multiply unit. It captures a vector of NGROUPS
// 128-bit groups on go and runs the serial core over the selected group
// range. It applies tail fill and returns the vector with a done pulse.
// Assumes NGROUPS >= 2.
module ghash_gfmul_unit
    import ghash_pkg::*;
#(
    parameter int NGROUPS = 4,
    localparam int NELEM  = NGROUPS * ELEMS_PER_BLK,
    localparam int CNT_W  = $clog2(NELEM + 1),
    localparam int VEC_W  = NGROUPS * BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             op,
    input  logic [CNT_W-1:0] start_elem,
    input  logic [CNT_W-1:0] len_elem,
    input  logic [CNT_W-1:0] total_elem,
    input  logic             tail_ones,
    input  logic [VEC_W-1:0] vec_y,
    input  logic [VEC_W-1:0] vec_x,
    input  logic [VEC_W-1:0] vec_h,
    output logic             busy,
    output logic             done,
    output logic [VEC_W-1:0] res_vec
);
    localparam int GSEL_W = (NGROUPS > 1) ? $clog2(NGROUPS) : 1;

    blk_t             y_q    [NGROUPS];
    blk_t             x_q    [NGROUPS];
    blk_t             h_q    [NGROUPS];
    blk_t             work_q [NGROUPS];
    ghash_op_e        op_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] total_q;
    logic             tail_q;

    logic              accept;
    logic              core_start;
    logic              core_busy;
    logic              core_done;
    logic              wr_en;
    logic              fin;
    logic [GSEL_W-1:0] grp_sel;
    blk_t              core_z;
    logic [VEC_W-1:0]  work_flat;
    logic [VEC_W-1:0]  filled;

    ghash_group_seq #(
        .NGROUPS (NGROUPS),
        .CNT_W   (CNT_W),
        .GSEL_W  (GSEL_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .start_elem (start_elem),
        .len_elem   (len_elem),
        .core_done  (core_done),
        .busy       (busy),
        .accept     (accept),
        .core_start (core_start),
        .wr_en      (wr_en),
        .fin        (fin),
        .grp_sel    (grp_sel)
    );

    ghash_mul_core core_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (core_start),
        .op    (op_q),
        .y_in  (y_q[grp_sel]),
        .x_in  (x_q[grp_sel]),
        .h_in  (h_q[grp_sel]),
        .busy  (core_busy),
        .done  (core_done),
        .z_out (core_z)
    );

    for (genvar g = 0; g < NGROUPS; g++) begin : g_pack
        assign work_flat[g*BLK_W +: BLK_W] = work_q[g];
    end

    ghash_tail_fill #(
        .NELEM (NELEM),
        .CNT_W (CNT_W)
    ) fill_i (
        .data_in  (work_flat),
        .len      (len_q),
        .total    (total_q),
        .enable   (tail_q),
        .data_out (filled)
    );

    // Operand capture on accept; write back each finished group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NGROUPS; g++) begin
                y_q[g]    <= '0;
                x_q[g]    <= '0;
                h_q[g]    <= '0;
                work_q[g] <= '0;
            end
            op_q    <= OP_MUL;
            len_q   <= '0;
            total_q <= '0;
            tail_q  <= 1'b0;
        end else if (accept) begin
            for (int g = 0; g < NGROUPS; g++) begin
                y_q[g]    <= vec_y[g*BLK_W +: BLK_W];
                x_q[g]    <= vec_x[g*BLK_W +: BLK_W];
                h_q[g]    <= vec_h[g*BLK_W +: BLK_W];
                work_q[g] <= vec_y[g*BLK_W +: BLK_W];
            end
            op_q    <= ghash_op_e'(op);
            len_q   <= len_elem;
            total_q <= total_elem;
            tail_q  <= tail_ones;
        end else if (wr_en) begin
            work_q[grp_sel] <= core_z;
        end
    end

    // Result publish and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vec <= '0;
            done    <= 1'b0;
        end else begin
            done <= fin;
            if (fin) res_vec <= filled;
        end
    end
endmodule

// File: rtl/ghash_gfmul_unit_chk.sv
// Protocol and timing checks for ghash_gfmul_unit, attached by bind.
// Assumes the core takes exactly 128 busy cycles per group.
module ghash_gfmul_unit_chk #(
    parameter int VEC_W = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic             busy,
    input logic             done,
    input logic [VEC_W-1:0] res_vec,
    input logic             core_start,
    input logic             core_busy,
    input logic             core_done
);
    logic       armed_q;
    logic [8:0] run_cnt_q;

    // Marks that one clean cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // Counts the busy cycles of the core for the current group.
    always_ff @(posedge clk) begin
        if (!rst_n)                      run_cnt_q <= '0;
        else if (core_start && !core_busy) run_cnt_q <= '0;
        else if (core_busy)              run_cnt_q <= run_cnt_q + 1'b1;
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy);

    p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !done) |-> $stable(res_vec));

    p_core_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> !core_busy);

    p_core_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> (run_cnt_q == 9'd128));
endmodule

bind ghash_gfmul_unit ghash_gfmul_unit_chk #(.VEC_W(VEC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .busy       (busy),
    .done       (done),
    .res_vec    (res_vec),
    .core_start (core_start),
    .core_busy  (core_busy),
    .core_done  (core_done)
);

// File: tb/ghash_gfmul_unit_tb_top.sv
// Directed bench for ghash_gfmul_unit with a carry-less reference product.
module ghash_gfmul_unit_tb_top;
    localparam int NG    = 4;
    localparam int NE    = NG * 4;
    localparam int CW    = $clog2(NE + 1);
    localparam int VW    = NG * 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic          op = 1'b0;
    logic [CW-1:0] start_elem = '0;
    logic [CW-1:0] len_elem = '0;
    logic [CW-1:0] total_elem = '0;
    logic          tail_ones = 1'b0;
    logic [VW-1:0] vec_y = '0;
    logic [VW-1:0] vec_x = '0;
    logic [VW-1:0] vec_h = '0;
    logic          busy;
    logic          done;
    logic [VW-1:0] res_vec;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ghash_gfmul_unit #(.NGROUPS(NG)) dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .op(op),
        .start_elem(start_elem), .len_elem(len_elem), .total_elem(total_elem),
        .tail_ones(tail_ones), .vec_y(vec_y), .vec_x(vec_x), .vec_h(vec_h),
        .busy(busy), .done(done), .res_vec(res_vec)
    );

    function automatic logic [127:0] mirror8(input logic [127:0] v);
        logic [127:0] r;
        for (int i = 0; i < 128; i++) r[i] = v[(i / 8) * 8 + 7 - (i % 8)];
        return r;
    endfunction

    // Full carry-less product followed by top-down reduction.
    function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
        logic [255:0] p = '0;
        logic [127:0] am = mirror8(a);
        logic [255:0] bm = {128'h0, mirror8(b)};
        for (int i = 0; i < 128; i++) if (am[i]) p = p ^ (bm << i);
        for (int k = 254; k >= 128; k--) begin
            if (p[k]) begin
                p[k] = 1'b0;
                p = p ^ (256'h87 << (k - 128));
            end
        end
        return mirror8(p[127:0]);
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [VW-1:0] rndvec();
        logic [VW-1:0] v;
        for (int g = 0; g < NG; g++) v[g*128 +: 128] = rnd128();
        return v;
    endfunction

    function automatic logic [VW-1:0] expect_vec(input logic o, input int st, input int ln,
            input int tot, input logic ta, input logic [VW-1:0] y, input logic [VW-1:0] x,
            input logic [VW-1:0] h);
        logic [VW-1:0] e = y;
        int last = (ln / 4 > NG) ? NG : ln / 4;
        for (int g = st / 4; g < last; g++)
            e[g*128 +: 128] = ref_mul(o ? (y[g*128 +: 128] ^ x[g*128 +: 128]) : y[g*128 +: 128],
                                      h[g*128 +: 128]);
        for (int el = 0; el < NE; el++)
            if (ta && el >= ln && el < tot) e[el*32 +: 32] = '1;
        return e;
    endfunction

    task automatic chk_vec(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Drives one run and returns clock edges from acceptance to done.
    task automatic run(input logic o, input int st, input int ln, input int tot,
                       input logic ta, output int lat);
        @(negedge clk);
        op = o; start_elem = CW'(st); len_elem = CW'(ln);
        total_elem = CW'(tot); tail_ones = ta; go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
        chk_int("R7 busy after accept", int'(busy), 1);
        lat = 0;
        while (!done && lat < 2000) begin
            @(posedge clk); lat++; @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk_int("R1 busy at reset", int'(busy), 0);
        chk_int("R1 done at reset", int'(done), 0);
        chk_vec("R1 result at reset", res_vec, '0);
    endtask

    task automatic t_identity();
        int lat;
        vec_y = rndvec(); vec_h = rndvec(); vec_x = rndvec();
        vec_y[127:0] = 128'h80;
        run(1'b0, 0, 16, 16, 1'b0, lat);
        chk_vec("R2 unit times H", res_vec[127:0], vec_h[127:0]);
        chk_int("R7 latency four groups", lat, 130 * 4 + 2);
        @(negedge clk);
        chk_int("R7 done one cycle", int'(done), 0);
    endtask

    task automatic t_zero_commute();
        int lat;
        logic [127:0] a = rnd128(), b = rnd128();
        logic [VW-1:0] first;
        vec_y = {a, 128'h0, a, b}; vec_h = {b, a, 128'h0, a}; vec_x = rndvec();
        run(1'b0, 0, 16, 16, 1'b0, lat);
        chk_vec("R3 zero key", res_vec[255:128], '0);
        chk_vec("R3 zero accumulator", res_vec[383:256], '0);
        chk_vec("R3 commutative", res_vec[127:0], res_vec[511:384]);
        chk_vec("R3 product vs model", res_vec[127:0], ref_mul(b, a));
        first = res_vec;
        vec_y = rndvec(); vec_h = rndvec();
        run(1'b0, 0, 16, 16, 1'b0, lat);
        chk_vec("R3 random groups", res_vec, expect_vec(1'b0, 0, 16, 16, 1'b0, vec_y, vec_x, vec_h));
        chk_int("R3 fresh result differs", int'(res_vec != first), 1);
    endtask

    task automatic t_hash();
        int lat;
        logic [VW-1:0] mul_res;
        vec_y = rndvec(); vec_h = rndvec(); vec_x = rndvec();
        run(1'b1, 0, 16, 16, 1'b0, lat);
        chk_vec("R4 hash step vs model", res_vec, expect_vec(1'b1, 0, 16, 16, 1'b0, vec_y, vec_x, vec_h));
        vec_x = '0;
        run(1'b0, 0, 16, 16, 1'b0, lat);
        mul_res = res_vec;
        run(1'b1, 0, 16, 16, 1'b0, lat);
        chk_vec("R4 hash with zero X equals multiply", res_vec, mul_res);
    endtask

    task automatic t_ranges();
        int lat;
        vec_y = rndvec(); vec_h = rndvec(); vec_x = rndvec();
        run(1'b1, 5, 11, 14, 1'b1, lat);
        chk_vec("R5 R6 mid-group range with tail fill", res_vec,
                expect_vec(1'b1, 5, 11, 14, 1'b1, vec_y, vec_x, vec_h));
        chk_vec("R6 element past total keeps Y", res_vec[511:448], vec_y[511:448]);
        chk_int("R7 latency one group", lat, 130 + 2);
        run(1'b1, 5, 11, 14, 1'b0, lat);
        chk_vec("R6 tail kept when flag clear", res_vec,
                expect_vec(1'b1, 5, 11, 14, 1'b0, vec_y, vec_x, vec_h));
        run(1'b0, 4, 13, 16, 1'b0, lat);
        chk_vec("R5 groups one and two only", res_vec,
                expect_vec(1'b0, 4, 13, 16, 1'b0, vec_y, vec_x, vec_h));
        chk_int("R7 latency two groups", lat, 130 * 2 + 2);
        run(1'b0, 8, 6, 12, 1'b1, lat);
        chk_vec("R5 empty range with tail", res_vec,
                expect_vec(1'b0, 8, 6, 12, 1'b1, vec_y, vec_x, vec_h));
        chk_int("R7 latency empty range", lat, 2);
    endtask

    task automatic t_busy_ignore();
        int lat = 0;
        logic [VW-1:0] y0, x0, h0;
        y0 = rndvec(); x0 = rndvec(); h0 = rndvec();
        vec_y = y0; vec_x = x0; vec_h = h0;
        @(negedge clk);
        op = 1'b1; start_elem = CW'(4); len_elem = CW'(8);
        total_elem = CW'(16); tail_ones = 1'b1; go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
        repeat (10) begin @(posedge clk); lat++; end
        @(negedge clk);
        vec_y = rndvec(); vec_x = rndvec(); vec_h = rndvec();
        op = 1'b0; start_elem = '0; len_elem = CW'(16); tail_ones = 1'b0; go = 1'b1;
        @(posedge clk); lat++;
        @(negedge clk);
        go = 1'b0;
        while (!done && lat < 2000) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        chk_vec("R8 result uses captured operands", res_vec,
                expect_vec(1'b1, 4, 8, 16, 1'b1, y0, x0, h0));
        chk_int("R8 latency unaffected by second go", lat, 130 + 2);
        @(negedge clk);
        chk_int("R8 no second run started", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_zero_commute();
        t_hash();
        t_ranges();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule